// File: doc/BRIEF.md
# Machine-Cycle 16-bit Timer

This block is a 16-bit up-counter that advances by one on every machine cycle, where one machine cycle is twelve input clocks. Software sets it up through a small byte-wide write port: a mode register picks the counting mode, a control register holds the run bit, the interrupt enable and the clear path for the overflow flag, and two count registers load the high and low count bytes on their own.

In use, software loads the two count bytes so that the counter reaches FFFFh after the wanted number of machine cycles. For example, FCh and 18h give a period of 1000 machine cycles. It then sets the run bit. When the count wraps from FFFFh to 0000h, the overflow flag is set. If the interrupt enable is set, an interrupt request is raised at the same time. The flag stays set until software clears it or the interrupt controller acknowledges it. Only the plain 16-bit counting mode is built.

Top module: `mct_timer`

## Requirements
- R1: While counting is enabled, the count rises by exactly one every 12 clocks. The first increment lands on the 12th rising edge after the edge that enabled counting, and FFFFh steps to 0000h.
- R2: Address 0 is the mode register. Counting is enabled only when mode bits [1:0] equal 01. The values 00, 10 and 11 hold the count unchanged.
- R3: Address 1 is the control register. Bit 0 is the run bit, and with run at 0 the count holds.
- R4: A write to address 2 loads the high count byte and a write to address 3 loads the low count byte. In each case the other byte keeps its value.
- R5: A count-byte write in the same clock as a machine-cycle increment wins: the written value is kept and no increment is applied.
- R6: The clock edge on which the count wraps from FFFFh to 0000h sets the overflow flag `ovf_o`.
- R7: `irq_o` is high exactly when the overflow flag is set and control bit 2 (interrupt enable) is 1.
- R8: The flag is cleared by an `irq_ack` pulse or by a control write with bit 1 at 0. A control write with bit 1 at 1 leaves it unchanged. A wrap in the same clock as a clear leaves the flag set.
- R9: Each time the run bit goes from 0 to 1, the machine-cycle divider restarts, so a stop and restart partway through a machine cycle again waits a full 12 clocks for the next increment.
- R10: After reset, the count, mode, run bit, interrupt enable and flag are all 0.
- R11: With the count bytes preloaded with FCh and 18h, the flag sets exactly 12000 clocks after the run write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 mode, 1 control, 2 count high, 3 count low |
| wr_data | input | 8 | Write data |
| irq_ack | input | 1 | Interrupt acknowledge, clears the overflow flag |
| count_o | output | 16 | Current count |
| ovf_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench lines a count-byte write up with the exact clock of a machine-cycle increment. A design with the wrong priority would show the written value plus one. It also lines an acknowledge up with a wrap, where a design with the wrong priority would lose the interrupt. It stops the timer halfway through a machine cycle and restarts it; a divider that kept its phase would increment after fewer than 12 clocks. It also checks the 1000-cycle preload down to the exact clock, which catches off-by-one errors in the divider or the wrap detection, and it runs every non-16-bit mode value to catch a design that counts in those modes.

// File: rtl/mct_pkg.sv
package mct_pkg;

    typedef enum logic [1:0] {
        SEL_MODE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_HIGH = 2'd2,
        SEL_LOW  = 2'd3
    } reg_sel_e;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_KEEP_BIT = 1;
    localparam int CTRL_IE_BIT   = 2;

    localparam logic [1:0] MODE_PLAIN16 = 2'b01;

    typedef struct packed {
        logic [1:0] mode;
        logic       run;
        logic       ie;
        logic       flag;
    } ctl_t;

endpackage

// File: rtl/mct_prescale.sv
module mct_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    output logic tick_o
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_d, phase_q;

    assign tick_o = enable_i && (phase_q == LAST);

    always_comb begin
        phase_d = phase_q;
        if (!enable_i || tick_o) begin
            phase_d = '0;
        end else begin
            phase_d = phase_q + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end
endmodule

// File: rtl/mct_count.sv
module mct_count #(
    parameter int W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_hi_i,
    input  logic          ld_lo_i,
    input  logic [W/2-1:0] ld_data_i,
    input  logic          tick_i,
    output logic [W-1:0]  count_o,
    output logic          wrap_o
);
    localparam int HW = W / 2;

    logic [W-1:0] cnt_d, cnt_q;
    logic         load;

    assign load    = ld_hi_i || ld_lo_i;
    assign wrap_o  = tick_i && !load && (&cnt_q);
    assign count_o = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            if (ld_hi_i) cnt_d[W-1:HW] = ld_data_i;
            if (ld_lo_i) cnt_d[HW-1:0] = ld_data_i;
        end else if (tick_i) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/mct_timer.sv
module mct_timer #(
    parameter int CYCLE_CLKS = 12,
    parameter int CNT_W      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [CNT_W/2-1:0] wr_data,
    input  logic               irq_ack,
    output logic [CNT_W-1:0]   count_o,
    output logic               ovf_o,
    output logic               irq_o
);
    import mct_pkg::*;

    ctl_t     ctl_d, ctl_q;
    logic     ld_hi, ld_lo;
    logic     cnt_en, tick, wrap;
    logic     run_q;
    reg_sel_e sel;

    assign sel    = reg_sel_e'(wr_addr);
    assign cnt_en = ctl_q.run && (ctl_q.mode == MODE_PLAIN16);
    assign run_q  = ctl_q.run;

    mct_prescale #(.DIV(CYCLE_CLKS)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (cnt_en),
        .tick_o   (tick)
    );

    mct_count #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_hi_i   (ld_hi),
        .ld_lo_i   (ld_lo),
        .ld_data_i (wr_data),
        .tick_i    (tick),
        .count_o   (count_o),
        .wrap_o    (wrap)
    );

    always_comb begin
        ctl_d = ctl_q;
        ld_hi = 1'b0;
        ld_lo = 1'b0;
        if (wr_en) begin
            case (sel)
                SEL_MODE: ctl_d.mode = wr_data[1:0];
                SEL_CTRL: begin
                    ctl_d.run = wr_data[CTRL_RUN_BIT];
                    ctl_d.ie  = wr_data[CTRL_IE_BIT];
                    if (!wr_data[CTRL_KEEP_BIT]) ctl_d.flag = 1'b0;
                end
                SEL_HIGH: ld_hi = 1'b1;
                SEL_LOW:  ld_lo = 1'b1;
                default:  ;
            endcase
        end
        if (irq_ack) ctl_d.flag = 1'b0;
        if (wrap)    ctl_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ovf_o = ctl_q.flag;
    assign irq_o = ctl_q.flag && ctl_q.ie;
endmodule

// File: rtl/mct_timer_chk.sv
module mct_timer_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic         irq_ack,
    input logic [W-1:0] count,
    input logic         ovf,
    input logic         irq,
    input logic         run
);
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && count != $past(count)) |-> count == W'($past(count) + 1'b1)); // R1

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_en) |=> $stable(count)); // R3

    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && $past(count) == {W{1'b1}} && count == '0) |-> ovf); // R6

    AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ovf); // R7

    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && count != {W{1'b1}}) |=> !ovf); // R8
endmodule

bind mct_timer mct_timer_chk #(.W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .irq_ack (irq_ack),
    .count   (count_o),
    .ovf     (ovf_o),
    .irq     (irq_o),
    .run     (run_q)
);

// File: tb/sim_mct_timer.sv
`timescale 1ns/1ps
module sim_mct_timer;
    localparam int CYC = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic        irq_ack = 1'b0;
    logic [15:0] count_o;
    logic        ovf_o, irq_o;

    int total = 0;
    int fails = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    int m_pre, m_cnt, m_mode, m_run, m_ie, m_flag;
    bit m_en, m_tick, m_ld;

    always #2.5 clk = ~clk;

    mct_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .irq_ack(irq_ack),
        .count_o(count_o), .ovf_o(ovf_o), .irq_o(irq_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_mode = 0; m_run = 0; m_ie = 0; m_flag = 0;
        end else begin
            m_en   = (m_run == 1) && (m_mode == 1);
            m_tick = m_en && (m_pre == CYC - 1);
            m_ld   = wr_en && (wr_addr == 2 || wr_addr == 3);
            if (!m_en || m_tick) m_pre = 0; else m_pre = m_pre + 1;
            if (m_tick && !m_ld && m_cnt == 16'hFFFF) m_flag = 1;
            else if (irq_ack || (wr_en && wr_addr == 1 && !wr_data[1])) m_flag = 0;
            if (m_ld) begin
                if (wr_addr == 2) m_cnt = (int'(wr_data) << 8) | (m_cnt & 8'hFF);
                else m_cnt = (m_cnt & 16'hFF00) | int'(wr_data);
            end else if (m_tick) begin
                m_cnt = (m_cnt + 1) % 65536;
            end
            if (wr_en && wr_addr == 0) m_mode = int'(wr_data[1:0]);
            if (wr_en && wr_addr == 1) begin
                m_run = int'(wr_data[0]);
                m_ie  = int'(wr_data[2]);
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(int'(count_o) == m_cnt, "R1 model count", int'(count_o), m_cnt);
            check(int'(ovf_o) == m_flag, "R6 model flag", int'(ovf_o), m_flag);
            check(int'(irq_o) == (m_flag & m_ie), "R7 model irq", int'(irq_o), m_flag & m_ie);
        end
    end

    always @(posedge clk) begin
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            total++; fails++;
            $display("FAIL watchdog R1 actual=%0d expected<=100000 cycles", cyc);
            summary();
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(count_o == 16'h0 && !ovf_o && !irq_o, "R10 reset state", int'(count_o), 0);
        rst_n = 1'b1;
        idle(2);

        // R1: pacing of 12 clocks
        wr(2'd0, 8'h01); wr(2'd2, 8'h00); wr(2'd3, 8'h00); wr(2'd1, 8'h01);
        idle(11); check(count_o == 16'd0, "R1 before 12th edge", int'(count_o), 0);
        idle(1);  check(count_o == 16'd1, "R1 12th edge", int'(count_o), 1);
        idle(12); check(count_o == 16'd2, "R1 24th edge", int'(count_o), 2);

        // R2: other mode values hold
        wr(2'd0, 8'h00); idle(40); check(count_o == 16'd2, "R2 mode 00 holds", int'(count_o), 2);
        wr(2'd0, 8'h02); idle(30); check(count_o == 16'd2, "R2 mode 10 holds", int'(count_o), 2);
        wr(2'd0, 8'h03); idle(30); check(count_o == 16'd2, "R2 mode 11 holds", int'(count_o), 2);
        wr(2'd0, 8'h01);
        idle(11); check(count_o == 16'd2, "R2 resume wait", int'(count_o), 2);
        idle(1);  check(count_o == 16'd3, "R2 resume step", int'(count_o), 3);

        // R3: run bit low holds
        wr(2'd1, 8'h00); idle(40); check(count_o == 16'd3, "R3 stopped holds", int'(count_o), 3);

        // R9: stop partway through a machine cycle, then restart
        wr(2'd1, 8'h01); idle(5); wr(2'd1, 8'h00); idle(3);
        check(count_o == 16'd3, "R9 partial cycle", int'(count_o), 3);
        wr(2'd1, 8'h01);
        idle(11); check(count_o == 16'd3, "R9 full wait after restart", int'(count_o), 3);
        idle(1);  check(count_o == 16'd4, "R9 step after restart", int'(count_o), 4);

        // R4: byte loads
        wr(2'd2, 8'hAB); check(count_o == 16'hAB04, "R4 high byte", int'(count_o), 16'hAB04);
        wr(2'd3, 8'h10); check(count_o == 16'hAB10, "R4 low byte", int'(count_o), 16'hAB10);

        // R5: write on the increment edge
        idle(9); wr(2'd3, 8'h77);
        check(count_o == 16'hAB77, "R5 write beats increment", int'(count_o), 16'hAB77);
        idle(12); check(count_o == 16'hAB78, "R1 next step", int'(count_o), 16'hAB78);

        // R11, R6, R7: 1000 machine cycle period
        wr(2'd1, 8'h00); wr(2'd2, 8'hFC); wr(2'd3, 8'h18); wr(2'd1, 8'h05);
        idle(11999);
        check(count_o == 16'hFFFF && !ovf_o, "R11 one clock before wrap", int'(count_o), 16'hFFFF);
        idle(1);
        check(count_o == 16'h0000, "R6 wrap to zero", int'(count_o), 0);
        check(ovf_o == 1'b1, "R11 flag at 12000 clocks", int'(ovf_o), 1);
        check(irq_o == 1'b1, "R7 irq with enable", int'(irq_o), 1);

        // R7/R8: keep bit set, enable off
        wr(2'd1, 8'h03);
        check(ovf_o == 1'b1, "R8 keep bit leaves flag", int'(ovf_o), 1);
        check(irq_o == 1'b0, "R7 irq masked", int'(irq_o), 0);
        wr(2'd1, 8'h01);
        check(ovf_o == 1'b0, "R8 control write clears", int'(ovf_o), 0);

        // R8: acknowledge clears
        wr(2'd1, 8'h00); wr(2'd2, 8'hFF); wr(2'd3, 8'hFF); wr(2'd1, 8'h05);
        idle(12);
        check(ovf_o == 1'b1 && count_o == 16'h0, "R6 wrap from FFFF", int'(ovf_o), 1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        check(ovf_o == 1'b0 && irq_o == 1'b0, "R8 ack clears", int'(ovf_o), 0);

        // R8: wrap and acknowledge together
        wr(2'd1, 8'h00); wr(2'd2, 8'hFF); wr(2'd3, 8'hFF); wr(2'd1, 8'h05);
        idle(11);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        check(ovf_o == 1'b1, "R8 set beats ack", int'(ovf_o), 1);

        idle(2);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule